// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block joins an A bus and a B bus with two independent storage paths, one for each direction. In each path a level-sensitive hold element and an edge capture register are merged into one storage word. A per-direction latch-enable selects the mode. With the enable high, data passes straight through. With it low, the stored word is held, and a rising edge of the direction's capture clock loads the current inputs. Each direction also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low.

Each port's three-state driver is split into a data bus and a drive flag, so that a wrapper at the pad level can turn the flag into high impedance. The direction capture clocks are treated as data: the block samples them on its own system clock and acts on a rising edge when it sees one. The two directions never interact. If both are enabled at once, the system around the block must resolve the conflict. The data width is a parameter and defaults to 36 bits.

Top module: `ubt_transceiver`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, with no clock edge needed, and tracks every change of `a_in`.
- R2: While `ab_le` is 0, the first system clock edge at which `ab_clk` is sampled 1 after being sampled 0 loads `a_in` into the A-to-B storage. From that edge on, `b_out` shows the loaded value.
- R3: While `ab_le` is 0 and no rising edge of `ab_clk` is seen, `b_out` keeps the stored value. Changes of `a_in` and falling edges of `ab_clk` have no effect on it.
- R4: When `ab_le` goes from 1 to 0, `b_out` holds the value `a_in` had at the last system clock edge at which `ab_le` was 1.
- R5: `b_drive` is 1 exactly when `ab_oe` is 1 (active-high enable).
- R6: `a_drive` is 1 exactly when `ba_oe_n` is 0 (active-low enable).
- R7: The B-to-A path follows R1 to R4 using `ba_le`, `ba_clk`, `b_in` and `a_out`.
- R8: Storage in a direction keeps loading according to its latch-enable and clock while that direction's drive flag is 0. The loaded value appears once the output is enabled.
- R9: A rising capture-clock edge while the latch-enable is 1 has no extra effect: the output keeps following the input.
- R10: Synchronous reset clears both storage words to zero. A capture clock that is held at 1 through the release of reset does not count as a rising edge.
- R11: Both directions can drive in the same cycle, and each computes its output from its own inputs only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the capture clocks and updates storage |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Data received from the A bus |
| b_in | input | WIDTH | Data received from the B bus |
| ab_le | input | 1 | A-to-B latch-enable: 1 for pass-through |
| ab_clk | input | 1 | A-to-B capture clock, acting on its rising edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch-enable: 1 for pass-through |
| ba_clk | input | 1 | B-to-A capture clock, acting on its rising edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | WIDTH | Data presented toward the A bus |
| a_drive | output | 1 | 1 when the A port drives, 0 for high impedance |
| b_out | output | WIDTH | Data presented toward the B bus |
| b_drive | output | 1 | 1 when the B port drives, 0 for high impedance |

## Verification
The bench builds the block with a 4-bit width. At that width, every possible data word can be pushed through each direction in pass-through, clocked capture, hold and latch-close sequences, with the expected value taken directly from the driven word or a fixed XOR of it. A small width also keeps each stored value clearly different from the disturbing inputs applied during hold. The bench therefore checks that the storage never leaks input changes, for all 16 codes in both directions.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int unsigned UBT_DEF_WIDTH = 36;

    // Control bundle for one direction
    typedef struct packed {
        logic latch_open;   // 1: pass-through
        logic cap_clk;      // capture clock, sampled level
        logic out_en;       // raw output enable as seen on the pin
    } ubt_ctrl_t;

    typedef enum logic [1:0] {
        UBT_PASS    = 2'd0,
        UBT_CAPTURE = 2'd1,
        UBT_HOLD    = 2'd2
    } ubt_mode_e;

    // Pass-through outranks a capture edge
    function automatic ubt_mode_e ubt_decode(input logic latch_open, input logic rise);
        if (latch_open)
            return UBT_PASS;
        else if (rise)
            return UBT_CAPTURE;
        else
            return UBT_HOLD;
    endfunction

endpackage

// File: rtl/ubt_edge_sense.sv
module ubt_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);

    logic prev;

    // History resets to 1 so a level already high at release is not an edge
    always_ff @(posedge clk) begin
        if (rst)
            prev <= 1'b1;
        else
            prev <= sig;
    end

    assign rise = sig & ~prev;

    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R2

endmodule

// File: rtl/ubt_path.sv
module ubt_path
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH         = UBT_DEF_WIDTH,
    parameter bit          OE_ACTIVE_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  ubt_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);

    logic             rise;
    ubt_mode_e        mode;
    logic [WIDTH-1:0] store;

    ubt_edge_sense u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (ctrl.cap_clk),
        .rise (rise)
    );

    assign mode = ubt_decode(ctrl.latch_open, rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            store <= '0;
        end else begin
            case (mode)
                UBT_PASS,
                UBT_CAPTURE: store <= din;
                default:     store <= store;
            endcase
        end
    end

    assign dout = (mode == UBT_PASS) ? din : store;

    generate
        if (OE_ACTIVE_LOW) begin : g_oe_low
            assign drive = ~ctrl.out_en;
        end else begin : g_oe_high
            assign drive = ctrl.out_en;
        end
    endgenerate

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.latch_open && rise) |=> (store == $past(din))); // R2
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.latch_open && $past(!ctrl.latch_open && !rise)) |-> (dout == $past(dout))); // R3
    AST_PASS_RETAINS: assert property (@(posedge clk) disable iff (rst)
        ctrl.latch_open |=> (store == $past(din))); // R4

endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH = UBT_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ab_oe,
    input  logic             ba_le,
    input  logic             ba_clk,
    input  logic             ba_oe_n,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive
);

    ubt_ctrl_t ab_ctrl;
    ubt_ctrl_t ba_ctrl;

    assign ab_ctrl = '{latch_open: ab_le, cap_clk: ab_clk, out_en: ab_oe};
    assign ba_ctrl = '{latch_open: ba_le, cap_clk: ba_clk, out_en: ba_oe_n};

    ubt_path #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_ab (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ab_ctrl),
        .din   (a_in),
        .dout  (b_out),
        .drive (b_drive)
    );

    ubt_path #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_ba (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ba_ctrl),
        .din   (b_in),
        .dout  (a_out),
        .drive (a_drive)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!ab_le && !ba_le) |-> (a_out == '0 && b_out == '0)); // R10

endmodule

// File: tb/ubt_transceiver_tb.sv
module ubt_transceiver_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         ab_le, ab_clk, ab_oe;
    logic         ba_le, ba_clk, ba_oe_n;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    ubt_transceiver #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
        .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Direction helpers: dir 0 is A-to-B, dir 1 is B-to-A
    task automatic set_in(input bit dir, input logic [W-1:0] v);
        if (dir) b_in = v; else a_in = v;
    endtask
    task automatic set_le(input bit dir, input logic v);
        if (dir) ba_le = v; else ab_le = v;
    endtask
    task automatic set_ck(input bit dir, input logic v);
        if (dir) ba_clk = v; else ab_clk = v;
    endtask
    function automatic int get_out(input bit dir);
        return dir ? int'(a_out) : int'(b_out);
    endfunction

    task automatic sweep(input bit dir);
        string tp, tc, th, tl, t9;
        tp = dir ? "R7 pass"    : "R1 pass";
        tc = dir ? "R7 capture" : "R2 capture";
        th = dir ? "R7 hold"    : "R3 hold";
        tl = dir ? "R7 close"   : "R4 close";
        t9 = dir ? "R9 ba"      : "R9 ab";
        for (int v = 0; v < (1 << W); v++) begin
            logic [W-1:0] d;
            d = W'(v);
            // clocked capture
            set_le(dir, 1'b0);
            set_ck(dir, 1'b0); set_in(dir, ~d); step();
            set_ck(dir, 1'b1); set_in(dir, d);  step();
            chk(tc, get_out(dir), int'(d));
            set_ck(dir, 1'b0); set_in(dir, ~d); step();
            chk(th, get_out(dir), int'(d));
            set_in(dir, d ^ 4'h5); step();
            chk(th, get_out(dir), int'(d));
            // pass-through
            set_le(dir, 1'b1); set_in(dir, d); #1;
            chk(tp, get_out(dir), int'(d));
            set_in(dir, d ^ 4'h3); #1;
            chk(tp, get_out(dir), int'(d ^ 4'h3));
            set_ck(dir, 1'b1); step();
            chk(t9, get_out(dir), int'(d ^ 4'h3));
            set_ck(dir, 1'b0); step();
            set_le(dir, 1'b0); set_in(dir, d ^ 4'h9); #1;
            chk(tl, get_out(dir), int'(d ^ 4'h3));
            step();
            chk(tl, get_out(dir), int'(d ^ 4'h3));
        end
    endtask

    initial begin
        #1_000_000;
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1;
        a_in = 4'hA; b_in = 4'h5;
        ab_le = 1'b0; ba_le = 1'b0;
        ab_clk = 1'b1; ba_clk = 1'b1;
        ab_oe = 1'b0; ba_oe_n = 1'b1;
        #2;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R10: storage zero, clocks held high give no capture
        chk("R10 b_out", int'(b_out), 0);
        chk("R10 a_out", int'(a_out), 0);
        chk("R5 b_drive off", int'(b_drive), 0);
        chk("R6 a_drive off", int'(a_drive), 0);
        ab_oe = 1'b1; ba_oe_n = 1'b0; #1;
        chk("R5 b_drive on", int'(b_drive), 1);
        chk("R6 a_drive on", int'(a_drive), 1);

        sweep(1'b0);
        sweep(1'b1);

        // R8: load while not driving
        ab_oe = 1'b0; ab_clk = 1'b0; step();
        ab_clk = 1'b1; a_in = 4'h6; step();
        chk("R8 b_drive", int'(b_drive), 0);
        ab_clk = 1'b0; a_in = 4'h1; ab_oe = 1'b1; step();
        chk("R8 b_out", int'(b_out), 6);
        ba_oe_n = 1'b1; ba_clk = 1'b0; step();
        ba_clk = 1'b1; b_in = 4'hB; step();
        chk("R8 a_drive", int'(a_drive), 0);
        ba_clk = 1'b0; b_in = 4'h2; ba_oe_n = 1'b0; step();
        chk("R8 a_out", int'(a_out), 11);

        // R11: both directions at once
        ab_le = 1'b1; ba_le = 1'b1; a_in = 4'h3; b_in = 4'hC; #1;
        chk("R11 b_out", int'(b_out), 3);
        chk("R11 a_out", int'(a_out), 12);
        chk("R11 drives", int'({a_drive, b_drive}), 3);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule